// File: doc/BRIEF.md
# Serial Controller FIFO Status and Interrupt Unit

This block sits inside a serial controller, beside its transmit and receive FIFOs (which it contains). It serves the register access path: a write to the data address pushes a frame into the transmit FIFO, and a read from the data address pops a frame from the receive FIFO. On the other side, the serial shifter pops transmit frames and pushes received frames. The unit tracks both fill levels and compares them with two programmable thresholds. It catches overflow and underflow caused by accesses, and presents a raw status word, a masked status word and one combined interrupt line.

The threshold registers hold only values below the FIFO depth. Software can therefore find the depth by writing rising values and reading each one back. Pulling the enable input low flushes both FIFOs and clears the sticky error flags.

Top module: `ssi_fifo_irq_unit`

## Requirements
- R1: After reset the mask is 5'h1F, both thresholds read 0, both levels read 0 and all sticky flags are 0. Because the empty transmit FIFO meets threshold 0, raw bit 0 and `irq_o` are 1.
- R2: With `en_i` high, a write to address 0 pushes `reg_wdata_i[WIDTH-1:0]` into the transmit FIFO when it is not full. `tx_data_o` presents the frames in write order and each `tx_pop_i` removes one. Address 3 reads the transmit level.
- R3: A data write while the transmit FIFO holds DEPTH entries is dropped and sets sticky raw bit 1 (transmit overflow).
- R4: A read of address 0 returns and removes the oldest receive frame. Frames come back in the order `rx_push_i` stored them. Address 4 reads the receive level. A data read while the receive FIFO is empty returns 0 and sets sticky raw bit 2 (receive underflow).
- R5: An `rx_push_i` while the receive FIFO holds DEPTH entries loses the frame and sets sticky raw bit 3 (receive overflow).
- R6: Raw bit 0 (transmit low) is 1 exactly when the transmit level is less than or equal to the transmit threshold at address 1.
- R7: Raw bit 4 (receive high) is 1 exactly when the receive level is greater than the receive threshold at address 2, that is threshold+1 entries or more.
- R8: A threshold write of a value below DEPTH is stored. A write of DEPTH or more is ignored and the register keeps its previous value, so the read-back differs from the value written.
- R9: Address 6 reads the raw status. Address 7 reads raw AND mask, where the mask is at address 5. `irq_o` is the OR of the masked bits.
- R10: A read of address 8 returns the raw status and clears sticky bits 1 to 3. An error event in the same cycle as the clear leaves its bit set.
- R11: While `en_i` is low, both FIFOs are held empty, the sticky flags are held at 0, and data writes and `rx_push_i` have no effect.
- R12: Unmapped addresses read 0. Thresholds and mask stay writable while `en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable; low flushes FIFOs and flags |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effects on data and clear addresses) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | BUS_W | Write data |
| reg_rdata_o | output | BUS_W | Read data, combinational from address and state |
| tx_pop_i | input | 1 | Shifter takes one transmit frame |
| tx_data_o | output | WIDTH | Oldest transmit frame |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| rx_push_i | input | 1 | Shifter delivers one receive frame |
| rx_data_i | input | WIDTH | Receive frame from the shifter |
| irq_o | output | 1 | Combined interrupt |

## Verification
The embedded assertions check the following on every cycle:
- a FIFO level never exceeds DEPTH, and a push into a full FIFO leaves its level unchanged;
- each error event sets its flag on the next edge;
- a flag stays set until a clear or a disable;
- disabling empties the flags;
- the stored thresholds stay below DEPTH.

Only the bench scenarios can show four other behaviours:
- frame ordering through both FIFOs, and that dropped frames never appear;
- the exact threshold comparisons at every level and threshold pair of a depth-4 build;
- the depth probe by read-back;
- the priority of a same-cycle event over a clear.

// File: rtl/ssi_fifo_irq_pkg.sv
package ssi_fifo_irq_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_DATA  = 4'd0;
  localparam logic [ADDR_W-1:0] A_TXTHR = 4'd1;
  localparam logic [ADDR_W-1:0] A_RXTHR = 4'd2;
  localparam logic [ADDR_W-1:0] A_TXLVL = 4'd3;
  localparam logic [ADDR_W-1:0] A_RXLVL = 4'd4;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd5;
  localparam logic [ADDR_W-1:0] A_RAW   = 4'd6;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd8;

  localparam int ST_W   = 5;
  localparam int ST_TXE = 0;
  localparam int ST_TXO = 1;
  localparam int ST_RXU = 2;
  localparam int ST_RXO = 3;
  localparam int ST_RXF = 4;
  localparam int ERR_N  = 3;
endpackage

// File: rtl/ssi_sync_fifo.sv
module ssi_sync_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [LW-1:0]    level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [CW-1:0]    wr_q, rd_q;
  logic [LW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign data_o  = mem_q[rd_q];
  assign level_o = cnt_q;

  function automatic logic [CW-1:0] nxt(input logic [CW-1:0] p);
    return (p == CW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  // R2 / R4: occupancy bounded by depth
  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH));

  // R3 / R5: a push into a full FIFO with no pop does not grow it
  a_r5_full_push_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ssi_irq_ctrl.sv
module ssi_irq_ctrl
  import ssi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BUS_W = 32,
  localparam int CW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LW-1:0]    tx_level_i,
  input  logic [LW-1:0]    rx_level_i,
  input  logic [ERR_N-1:0] err_ev_i,
  input  logic             clr_i,
  input  logic             tx_thr_we_i,
  input  logic             rx_thr_we_i,
  input  logic             mask_we_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [CW-1:0]    tx_thr_o,
  output logic [CW-1:0]    rx_thr_o,
  output logic [ST_W-1:0]  mask_o,
  output logic [ST_W-1:0]  raw_o,
  output logic [ST_W-1:0]  masked_o,
  output logic             irq_o
);
  logic             in_range;
  logic [ERR_N-1:0] err_q;

  assign in_range = (wdata_i < BUS_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_o <= '0;
      rx_thr_o <= '0;
      mask_o   <= '1;
    end else begin
      if (tx_thr_we_i && in_range) tx_thr_o <= wdata_i[CW-1:0];
      if (rx_thr_we_i && in_range) rx_thr_o <= wdata_i[CW-1:0];
      if (mask_we_i) mask_o <= wdata_i[ST_W-1:0];
    end
  end

  for (genvar g = 0; g < ERR_N; g++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      err_q[g] <= 1'b0;
      else if (!en_i)   err_q[g] <= 1'b0;
      else              err_q[g] <= (err_q[g] & ~clr_i) | err_ev_i[g];
    end
  end

  always_comb begin
    raw_o         = '0;
    raw_o[ST_TXE] = (tx_level_i <= LW'(tx_thr_o));
    raw_o[ST_RXF] = (rx_level_i >  LW'(rx_thr_o));
    raw_o[ST_TXO] = err_q[0];
    raw_o[ST_RXU] = err_q[1];
    raw_o[ST_RXO] = err_q[2];
  end

  assign masked_o = raw_o & mask_o;
  assign irq_o    = |masked_o;

  // R8: stored thresholds always below depth
  a_r8_thr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_thr_o <= CW'(DEPTH - 1)) && (rx_thr_o <= CW'(DEPTH - 1)));

  // R3 / R4 / R5: an enabled event raises its flag on the next edge
  a_r3_event_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && err_ev_i[0]) |=> raw_o[ST_TXO]);

  // R10: flags persist until clear or disable
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && raw_o[ST_RXO]) |=> raw_o[ST_RXO]);

  // R11: disable empties flags
  a_r11_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (raw_o[ST_RXO:ST_TXO] == '0));
endmodule

// File: rtl/ssi_fifo_irq_unit.sv
module ssi_fifo_irq_unit
  import ssi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter int BUS_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  input  logic              tx_pop_i,
  output logic [WIDTH-1:0]  tx_data_o,
  output logic              tx_empty_o,
  input  logic              rx_push_i,
  input  logic [WIDTH-1:0]  rx_data_i,
  output logic              irq_o
);
  localparam int CW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic             data_we, data_re, clr_re;
  logic [LW-1:0]    tx_lvl, rx_lvl;
  logic             tx_full, rx_full, rx_empty;
  logic [WIDTH-1:0] rx_head;
  logic [ERR_N-1:0] err_ev;
  logic [CW-1:0]    tx_thr, rx_thr;
  logic [ST_W-1:0]  mask, raw, masked;

  assign data_we = reg_we_i & (reg_addr_i == A_DATA);
  assign data_re = reg_re_i & (reg_addr_i == A_DATA);
  assign clr_re  = reg_re_i & (reg_addr_i == A_CLR);

  ssi_sync_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i (~en_i),
    .push_i  (data_we),
    .data_i  (reg_wdata_i[WIDTH-1:0]),
    .pop_i   (tx_pop_i),
    .data_o  (tx_data_o),
    .level_o (tx_lvl),
    .full_o  (tx_full),
    .empty_o (tx_empty_o)
  );

  ssi_sync_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i (~en_i),
    .push_i  (rx_push_i),
    .data_i  (rx_data_i),
    .pop_i   (data_re),
    .data_o  (rx_head),
    .level_o (rx_lvl),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign err_ev[0] = en_i & data_we & tx_full;
  assign err_ev[1] = en_i & data_re & rx_empty;
  assign err_ev[2] = en_i & rx_push_i & rx_full;

  ssi_irq_ctrl #(.DEPTH(DEPTH), .BUS_W(BUS_W)) u_irq (
    .clk_i, .rst_ni, .en_i,
    .tx_level_i  (tx_lvl),
    .rx_level_i  (rx_lvl),
    .err_ev_i    (err_ev),
    .clr_i       (clr_re),
    .tx_thr_we_i (reg_we_i & (reg_addr_i == A_TXTHR)),
    .rx_thr_we_i (reg_we_i & (reg_addr_i == A_RXTHR)),
    .mask_we_i   (reg_we_i & (reg_addr_i == A_MASK)),
    .wdata_i     (reg_wdata_i),
    .tx_thr_o    (tx_thr),
    .rx_thr_o    (rx_thr),
    .mask_o      (mask),
    .raw_o       (raw),
    .masked_o    (masked),
    .irq_o       (irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      A_DATA:  reg_rdata_o = rx_empty ? '0 : BUS_W'(rx_head);
      A_TXTHR: reg_rdata_o = BUS_W'(tx_thr);
      A_RXTHR: reg_rdata_o = BUS_W'(rx_thr);
      A_TXLVL: reg_rdata_o = BUS_W'(tx_lvl);
      A_RXLVL: reg_rdata_o = BUS_W'(rx_lvl);
      A_MASK:  reg_rdata_o = BUS_W'(mask);
      A_RAW:   reg_rdata_o = BUS_W'(raw);
      A_STAT:  reg_rdata_o = BUS_W'(masked);
      A_CLR:   reg_rdata_o = BUS_W'(raw);
      default: reg_rdata_o = '0;
    endcase
  end

  // R4: empty data read raises the underflow flag
  a_r4_underflow_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && data_re && rx_empty) |=> raw[ST_RXU]);

  // R5: push into full receive FIFO raises the overflow flag
  a_r5_rx_overflow_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rx_push_i && rx_full) |=> raw[ST_RXO]);

  // R11: disabled controller holds both FIFOs empty
  a_r11_disabled_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tx_lvl == '0 && rx_lvl == '0));
endmodule

// File: tb/tb_ssi_fifo_irq_unit.sv
module tb_ssi_fifo_irq_unit;
  localparam int DEPTH = 4;
  localparam int WIDTH = 8;
  localparam int BUS_W = 32;

  logic clk = 0, rst_ni = 0, en = 0;
  logic we = 0, re = 0, tx_pop = 0, rx_push = 0;
  logic [3:0] addr = '0;
  logic [BUS_W-1:0] wdata = '0, rdata;
  logic [WIDTH-1:0] tx_data, rx_data = '0;
  logic tx_empty, irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ssi_fifo_irq_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BUS_W(BUS_W)) dut (
    .clk_i(clk), .rst_ni, .en_i(en),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .tx_empty_o(tx_empty),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1; addr = 4'(a); wdata = BUS_W'(d);
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); re = 1; addr = 4'(a); #1 d = int'(rdata);
    @(negedge clk); re = 0;
  endtask

  task automatic pop_tx(output int d);
    @(negedge clk); #1 d = int'(tx_data); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic push_rx(input int d);
    @(negedge clk); rx_push = 1; rx_data = WIDTH'(d);
    @(negedge clk); rx_push = 0;
  endtask

  task automatic flush();
    @(negedge clk); en = 0;
    @(negedge clk); en = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_ni = 1; en = 1;
    // R1 reset state
    rd(1, v); check("R1 tx thr", v, 0);
    rd(2, v); check("R1 rx thr", v, 0);
    rd(5, v); check("R1 mask", v, 31);
    rd(3, v); check("R1 tx lvl", v, 0);
    rd(4, v); check("R1 rx lvl", v, 0);
    rd(6, v); check("R1 raw", v, 1);
    check("R1 irq", int'(irq), 1);
    rd(11, v); check("R12 unmapped", v, 0);

    // R8 depth probe by read-back
    for (int t = 0; t < 8; t++) begin
      wr(1, t); rd(1, v); check("R8 tx thr", v, (t < DEPTH) ? t : DEPTH - 1);
      wr(2, t); rd(2, v); check("R8 rx thr", v, (t < DEPTH) ? t : DEPTH - 1);
    end

    // R6 / R2 transmit threshold sweep and order
    for (int t = 0; t < DEPTH; t++) begin
      flush(); wr(1, t);
      for (int l = 0; l <= DEPTH; l++) begin
        rd(3, v); check("R2 tx lvl", v, l);
        rd(6, v); check("R6 txe", v & 1, (l <= t) ? 1 : 0);
        if (l < DEPTH) wr(0, t * 16 + l);
      end
      for (int k = 0; k < DEPTH; k++) begin
        pop_tx(v); check("R2 tx order", v, t * 16 + k);
      end
      check("R2 tx empty", int'(tx_empty), 1);
    end

    // R3 transmit overflow drops frame; R10 clear
    flush(); wr(1, 0);
    for (int k = 0; k < DEPTH; k++) wr(0, 160 + k);
    wr(0, 238);
    rd(3, v); check("R3 lvl", v, DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      pop_tx(v); check("R3 kept order", v, 160 + k);
    end
    rd(6, v); check("R3 sticky txo", (v >> 1) & 1, 1);
    rd(8, v); check("R10 clr returns raw", (v >> 1) & 1, 1);
    rd(6, v); check("R10 cleared", (v >> 1) & 1, 0);

    // R7 / R4 receive threshold sweep and order
    for (int t = 0; t < DEPTH; t++) begin
      flush(); wr(2, t);
      for (int l = 0; l <= DEPTH; l++) begin
        rd(4, v); check("R4 rx lvl", v, l);
        rd(6, v); check("R7 rxf", (v >> 4) & 1, (l > t) ? 1 : 0);
        if (l < DEPTH) push_rx(t * 16 + l + 1);
      end
      for (int k = 0; k < DEPTH; k++) begin
        rd(0, v); check("R4 rx order", v, t * 16 + k + 1);
      end
      rd(6, v); check("R4 no error", (v >> 2) & 3, 0);
    end

    // R5 receive overflow, R4 underflow
    flush(); wr(2, 0);
    for (int k = 0; k < DEPTH; k++) push_rx(64 + k);
    push_rx(85);
    rd(6, v); check("R5 rxo", (v >> 3) & 1, 1);
    for (int k = 0; k < DEPTH; k++) begin
      rd(0, v); check("R5 frame lost", v, 64 + k);
    end
    rd(0, v); check("R4 empty read value", v, 0);
    rd(6, v); check("R4 rxu", (v >> 2) & 1, 1);

    // R9 mask sweep with raw = txe|rxu|rxo = 5'b01101
    wr(1, 0);
    rd(6, v); check("R9 raw setup", v, 13);
    for (int m = 0; m < 32; m++) begin
      wr(5, m);
      check("R9 irq", int'(irq), ((13 & m) != 0) ? 1 : 0);
      rd(7, v); check("R9 masked", v, 13 & m);
    end
    wr(5, 31);

    // R10 same-cycle event wins over clear
    for (int k = 0; k < DEPTH; k++) push_rx(k);
    rd(8, v);
    @(negedge clk); re = 1; addr = 4'd8; rx_push = 1; rx_data = 8'h77;
    @(negedge clk); re = 0; rx_push = 0;
    rd(6, v); check("R10 set wins", (v >> 3) & 1, 1);

    // R11 disable flushes, clears, ignores data traffic; R12 config writable
    wr(0, 1); wr(0, 2);
    @(negedge clk); en = 0;
    wr(0, 9); push_rx(9); wr(1, 2);
    rd(3, v); check("R11 tx lvl off", v, 0);
    rd(4, v); check("R11 rx lvl off", v, 0);
    rd(6, v); check("R11 flags off", (v >> 1) & 7, 0);
    rd(1, v); check("R12 thr while off", v, 2);
    @(negedge clk); en = 1;
    rd(3, v); check("R11 tx lvl on", v, 0);
    rd(0, v); check("R11 rx empty read", v, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule